// File: doc/BRIEF.md
# Multiply-Based Logical Shifter

This block shifts a 32-bit word left or right by a variable amount between 0 and 31. It contains no mux-tree barrel shifter. Every shift is a single integer multiply of the word by a one-hot power of two that is decoded from the count. The multiply is a plain `*` operator, so synthesis can place it on a hard multiplier. That keeps the wide variable-shift logic off the critical path.

A left shift keeps the low half of the product. A right shift is built in one of two ways, chosen by the `RSH_MODE` parameter:

- **Mirror mode:** the word is bit-reversed, multiplied by 2^n, cut back to its low half, and reversed again.
- **High-slice mode:** the word is multiplied by 2^(W-n) and the upper half of the product is kept.

Vacated positions always fill with zeros. The path holds `PIPE` register stages (1 to 3). The valid strobe travels through the same stages, so a result leaves exactly `PIPE` cycles after its operand was accepted. A new operand can be accepted on every cycle.

Top module: `mulshift_top`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0.
- R2: With `in_dir` = 0 (left), the result equals `in_data << in_cnt`. The low bits fill with zeros and bits shifted past bit 31 are lost.
- R3: With `in_dir` = 1 (right), the result equals `in_data >> in_cnt` with zero fill at the top. This holds in both right-shift modes: `RSH_MODE` = 0 (mirror) and `RSH_MODE` = 1 (high slice).
- R4: A count of 0 returns `in_data` unchanged in both directions.
- R5: `out_valid` equals `in_valid` from exactly `PIPE` cycles earlier, and `out_data` belongs to that same operand.
- R6: Operands given on consecutive cycles, with changing direction and count, each come out correctly on consecutive cycles.
- R7: A cycle with `in_valid` low produces `out_valid` low `PIPE` cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | Word to shift |
| in_cnt | input | 5 | Shift amount, 0 to 31 |
| in_dir | input | 1 | 0 = left, 1 = right |
| out_valid | output | 1 | Result strobe, `PIPE` cycles after `in_valid` |
| out_data | output | 32 | Shifted word |

## Verification
Left and right shifts share one multiplier, and only the registered direction bit tells the output stage which slice to keep. A left result and a right result can therefore sit in adjacent pipeline stages in the same cycle. The bench provokes this by alternating direction and count on every cycle of a gap-free burst. It also interleaves random bubbles, so that valid and invalid stages neighbour each other.

Two instances, one per right-shift mode, are checked every cycle. Each is judged against a behavioural queue that applies the language's own `<<` and `>>` operators `PIPE` cycles after the operand entered. Any mix-up of direction or slice between stages then shows up as a wrong word.

// File: rtl/mulshift_pkg.sv
package mulshift_pkg;

    // Direction encoding seen on in_dir
    typedef enum logic {
        SHIFT_LEFT  = 1'b0,
        SHIFT_RIGHT = 1'b1
    } shift_dir_e;

    // How a right shift is derived from the product
    typedef enum logic {
        RSH_MIRROR    = 1'b0,
        RSH_HIGHSLICE = 1'b1
    } rsh_mode_e;

endpackage

// File: rtl/mulshift_prep.sv
module mulshift_prep
    import mulshift_pkg::*;
#(
    parameter int        DATA_W   = 32,
    parameter rsh_mode_e RSH_MODE = RSH_MIRROR,
    localparam int       CNT_W    = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              dir_i,
    output logic [DATA_W-1:0] mcand_o,
    output logic [DATA_W:0]   factor_o
);

    function automatic logic [DATA_W-1:0] mirror(input logic [DATA_W-1:0] x);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[i] = x[DATA_W-1-i];
        return r;
    endfunction

    localparam logic [DATA_W:0] ONE = (DATA_W+1)'(1);

    generate
        if (RSH_MODE == RSH_HIGHSLICE) begin : g_slice
            logic [CNT_W:0] up_amt;
            always_comb begin
                up_amt = (CNT_W+1)'(DATA_W) - {1'b0, cnt_i};
                mcand_o = data_i;
                if (dir_i == SHIFT_RIGHT) factor_o = ONE << up_amt;
                else                      factor_o = ONE << cnt_i;
            end
        end else begin : g_mirror
            always_comb begin
                factor_o = ONE << cnt_i;
                if (dir_i == SHIFT_RIGHT) mcand_o = mirror(data_i);
                else                      mcand_o = data_i;
            end
        end
    endgenerate

endmodule

// File: rtl/mulshift_pipe.sv
module mulshift_pipe #(
    parameter int  DATA_W = 32,
    parameter int  PIPE   = 2,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic              dir_i,
    input  logic [DATA_W-1:0] mcand_i,
    input  logic [DATA_W:0]   factor_i,
    output logic              vld_o,
    output logic              dir_o,
    output logic [PROD_W-1:0] prod_o
);

    // Stage 1: operand registers feeding the multiplier
    logic              v1_q, d1_q;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W:0]   b_q;
    logic [PROD_W-1:0] prod_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            d1_q <= 1'b0;
            a_q  <= '0;
            b_q  <= '0;
        end else begin
            v1_q <= vld_i;
            d1_q <= dir_i;
            a_q  <= mcand_i;
            b_q  <= factor_i;
        end
    end

    // Largest product is (2^W - 1) * 2^W, which fits in 2W bits
    assign prod_c = PROD_W'(a_q) * PROD_W'(b_q);

    generate
        if (PIPE >= 2) begin : g_st2
            logic              v2_q, d2_q;
            logic [PROD_W-1:0] p2_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v2_q <= 1'b0;
                    d2_q <= 1'b0;
                    p2_q <= '0;
                end else begin
                    v2_q <= v1_q;
                    d2_q <= d1_q;
                    p2_q <= prod_c;
                end
            end
            if (PIPE >= 3) begin : g_st3
                logic              v3_q, d3_q;
                logic [PROD_W-1:0] p3_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        v3_q <= 1'b0;
                        d3_q <= 1'b0;
                        p3_q <= '0;
                    end else begin
                        v3_q <= v2_q;
                        d3_q <= d2_q;
                        p3_q <= p2_q;
                    end
                end
                assign vld_o  = v3_q;
                assign dir_o  = d3_q;
                assign prod_o = p3_q;
            end else begin : g_end2
                assign vld_o  = v2_q;
                assign dir_o  = d2_q;
                assign prod_o = p2_q;
            end
        end else begin : g_end1
            assign vld_o  = v1_q;
            assign dir_o  = d1_q;
            assign prod_o = prod_c;
        end
    endgenerate

endmodule

// File: rtl/mulshift_pick.sv
module mulshift_pick
    import mulshift_pkg::*;
#(
    parameter int        DATA_W   = 32,
    parameter rsh_mode_e RSH_MODE = RSH_MIRROR
) (
    input  logic [2*DATA_W-1:0] prod_i,
    input  logic                dir_i,
    output logic [DATA_W-1:0]   data_o
);

    function automatic logic [DATA_W-1:0] mirror(input logic [DATA_W-1:0] x);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[i] = x[DATA_W-1-i];
        return r;
    endfunction

    logic [DATA_W-1:0] lo_half, hi_half;
    assign lo_half = prod_i[DATA_W-1:0];
    assign hi_half = prod_i[2*DATA_W-1:DATA_W];

    generate
        if (RSH_MODE == RSH_HIGHSLICE) begin : g_slice
            always_comb begin
                if (dir_i == SHIFT_RIGHT) data_o = hi_half;
                else                      data_o = lo_half;
            end
        end else begin : g_mirror
            logic unused_hi;
            assign unused_hi = ^hi_half;
            always_comb begin
                if (dir_i == SHIFT_RIGHT) data_o = mirror(lo_half);
                else                      data_o = lo_half;
            end
        end
    endgenerate

endmodule

// File: rtl/mulshift_top.sv
module mulshift_top
    import mulshift_pkg::*;
#(
    parameter int        DATA_W   = 32,
    parameter int        PIPE     = 2,
    parameter rsh_mode_e RSH_MODE = RSH_MIRROR,
    localparam int       CNT_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CNT_W-1:0]  in_cnt,
    input  logic              in_dir,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic [DATA_W-1:0]   mcand;
    logic [DATA_W:0]     factor;
    logic [2*DATA_W-1:0] prod;
    logic                dir_late;

    mulshift_prep #(.DATA_W(DATA_W), .RSH_MODE(RSH_MODE)) u_prep (
        .data_i   (in_data),
        .cnt_i    (in_cnt),
        .dir_i    (in_dir),
        .mcand_o  (mcand),
        .factor_o (factor)
    );

    mulshift_pipe #(.DATA_W(DATA_W), .PIPE(PIPE)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (in_valid),
        .dir_i    (in_dir),
        .mcand_i  (mcand),
        .factor_i (factor),
        .vld_o    (out_valid),
        .dir_o    (dir_late),
        .prod_o   (prod)
    );

    mulshift_pick #(.DATA_W(DATA_W), .RSH_MODE(RSH_MODE)) u_pick (
        .prod_i (prod),
        .dir_i  (dir_late),
        .data_o (out_data)
    );

endmodule

// File: rtl/mulshift_chk.sv
module mulshift_chk #(
    parameter int  DATA_W = 32,
    parameter int  PIPE   = 2,
    localparam int CNT_W  = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [CNT_W-1:0]  in_cnt,
    input logic              in_dir,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    // Cycles since reset release, saturating once the pipe is full
    logic [2:0] seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     seen <= '0;
        else if (seen < 3'(PIPE))       seen <= seen + 3'd1;
    end

    logic full;
    assign full = (seen >= 3'(PIPE));

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!out_valid);
        end
    end

    // R5 R7
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (out_valid == $past(in_valid, PIPE)));

    // R2
    left_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && out_valid && !$past(in_dir, PIPE))
            |-> (out_data == ($past(in_data, PIPE) << $past(in_cnt, PIPE))));

    // R3
    right_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && out_valid && $past(in_dir, PIPE))
            |-> (out_data == ($past(in_data, PIPE) >> $past(in_cnt, PIPE))));

    // R4
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && out_valid && ($past(in_cnt, PIPE) == '0))
            |-> (out_data == $past(in_data, PIPE)));

endmodule

bind mulshift_top mulshift_chk #(.DATA_W(DATA_W), .PIPE(PIPE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_cnt    (in_cnt),
    .in_dir    (in_dir),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_mulshift_top.sv
module tb_mulshift_top;
    import mulshift_pkg::*;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [4:0]  in_cnt = '0;
    logic        in_dir = 1'b0;
    logic        ov_m, ov_s;
    logic [31:0] od_m, od_s;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    string phase = "sweep";

    typedef struct {
        bit          v;
        logic [31:0] d;
        int          n;
        bit          dir;
    } rec_t;
    rec_t q[$];

    always #4 clk = ~clk;

    mulshift_top #(.DATA_W(32), .PIPE(LAT), .RSH_MODE(RSH_MIRROR)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_cnt(in_cnt), .in_dir(in_dir), .out_valid(ov_m), .out_data(od_m));

    mulshift_top #(.DATA_W(32), .PIPE(LAT), .RSH_MODE(RSH_HIGHSLICE)) dut_slice (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_cnt(in_cnt), .in_dir(in_dir), .out_valid(ov_s), .out_data(od_s));

    task automatic judge(string who, logic v_act, logic [31:0] d_act, rec_t r);
        logic [31:0] expd;
        string tag;
        compared++;
        tag = r.v ? "R5" : "R7";
        if (v_act !== r.v) begin
            mismatched++;
            $display("FAIL %s %s [%s] valid actual=%b expected=%b", tag, who, phase, v_act, r.v);
            return;
        end
        if (!r.v) return;
        expd = r.dir ? (r.d >> r.n) : (r.d << r.n);
        if (r.n == 0)   tag = "R4";
        else if (r.dir) tag = "R3";
        else            tag = "R2";
        compared++;
        if (d_act !== expd) begin
            mismatched++;
            $display("FAIL %s %s [%s] d=%h n=%0d dir=%0d actual=%h expected=%h",
                     tag, who, phase, r.d, r.n, r.dir, d_act, expd);
        end
    endtask

    task automatic step(bit v, logic [31:0] d, int n, bit dir);
        rec_t r;
        in_valid = v;
        in_data  = d;
        in_cnt   = n[4:0];
        in_dir   = dir;
        @(posedge clk);
        r.v = v; r.d = d; r.n = n; r.dir = dir;
        q.push_back(r);
        @(negedge clk);
        if (q.size() == LAT) begin
            r = q.pop_front();
            judge("mirror", ov_m, od_m, r);
            judge("slice",  ov_s, od_s, r);
        end
    endtask

    initial begin
        logic [31:0] pats [6];
        rec_t idle;
        pats[0] = 32'hFFFF_FFFF;
        pats[1] = 32'h8000_0000;
        pats[2] = 32'h0000_0001;
        pats[3] = 32'h8000_0001;
        pats[4] = 32'hA5C3_0F96;
        pats[5] = 32'h0001_0000;

        // R1: outputs quiet while reset is held
        repeat (3) @(negedge clk);
        compared++;
        if (ov_m !== 1'b0 || ov_s !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 reset valid actual=%b/%b expected=0/0", ov_m, ov_s);
        end
        rst_n = 1'b1;
        idle.v = 1'b0; idle.d = '0; idle.n = 0; idle.dir = 1'b0;
        for (int k = 0; k < LAT - 1; k++) q.push_back(idle);

        // R2 R3 R4: every count, both directions, corner patterns
        phase = "sweep";
        for (int p = 0; p < 6; p++)
            for (int dr = 0; dr < 2; dr++)
                for (int n = 0; n < 32; n++)
                    step(1'b1, pats[p], n, dr[0]);

        // R7: bubbles only
        phase = "R7 idle";
        for (int k = 0; k < 8; k++) step(1'b0, 32'hDEAD_BEEF, 7, 1'b1);

        // R6: gap-free burst alternating direction and count
        phase = "R6 burst";
        for (int k = 0; k < 400; k++)
            step(1'b1, $urandom(), k % 32, k[0]);

        // R5 R7: random stream with random bubbles
        phase = "R5 random";
        for (int k = 0; k < 3000; k++)
            step(($urandom() % 4) != 0, $urandom(), $urandom() % 32, $urandom() % 2 == 1);

        // drain
        phase = "drain";
        for (int k = 0; k < LAT + 2; k++) step(1'b0, '0, 0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            mismatched++;
            $display("FAIL R5 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule